// File: doc/BRIEF.md
# Dual-Field Bit-Serial Montgomery Multiplier

This block computes a Montgomery product in either of two arithmetic settings with a single shared datapath. With the field-select input high it works on odd integer moduli and returns a·b·2^-K reduced modulo the modulus. With the field-select input low it works on binary polynomials and returns a(x)·b(x)·x^-K reduced modulo the field polynomial. The field polynomial has an implied leading term x^K, so the modulus port carries only its K lower coefficients.

One bit of the multiplier operand is consumed per clock, least significant bit first. Each step adds the multiplicand when that bit is set. It then adds the modulus when the low accumulator bit is set and halves the result. The same adder cells are used in both settings: in polynomial mode every carry is forced to zero, so each addition becomes a bitwise XOR. After the last step, integer mode subtracts the modulus once if the accumulator is not below it. Polynomial mode never subtracts.

The caller pulses `start` with operands already reduced: a, b below the modulus in integer mode, and an odd modulus or a set constant term. `busy` then stays high until the result is written and `done` pulses for one clock.

Top module: `dualfield_mont_mul`

## Requirements
- R1: With `field_sel`=1 and an odd modulus p, `product` equals the unique r in [0,p) with r·2^K ≡ a·b (mod p).
- R2: With `field_sel`=0, `product` equals the unique polynomial r of degree below K with r(x)·x^K ≡ a(x)·b(x) modulo x^K + modulus(x). Bit i of each port is the coefficient of x^i.
- R3: In polynomial mode no carry propagates between bit positions: all-ones operands give the carry-free result, not the integer one.
- R4: `done` goes high exactly K+1 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises, and is low while `done` is high.
- R5: `done` is high for exactly one clock cycle per operation.
- R6: `product` holds its value from `done` until the next operation writes a new result.
- R7: A `start` pulse while `busy` is high is ignored: the running operation finishes with its own result and timing.
- R8: In integer mode the result is never at or above the modulus, including the corner cases a=b=p-1, a=0 and p=3.
- R9: Operands, modulus and `field_sel` are captured on the accepting edge. Changes to them while `busy` is high have no effect on the result.
- R10: After reset `busy`=0, `done`=0 and `product`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| field_sel | input | 1 | 1 = integer modulus, 0 = binary polynomial |
| op_a | input | K | Multiplier operand, scanned LSB first |
| op_b | input | K | Multiplicand operand |
| modulus | input | K | Integer modulus, or low K coefficients of the field polynomial |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `product` is written |
| product | output | K | Montgomery product |

## Verification
The bench builds the block with K=12. With that width, a double-width reference computed in 64-bit bench arithmetic covers every integer and polynomial product. The small modulus space makes the extremes easy to reach: p=3, p=4095, the maximal operand p-1 and all-ones polynomials. Random moduli and operands spread over the full 12-bit range, and directed runs disturb `start`, the operands and `field_sel` while an operation is in flight.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mm_state_e;

  // Sum output of one dual-field adder cell.
  function automatic logic cell_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // Carry output of one dual-field adder cell; forced low in polynomial mode.
  function automatic logic cell_carry(input logic x, input logic y, input logic c,
                                      input logic int_mode);
    return int_mode & ((x & y) | (x & c) | (y & c));
  endfunction

endpackage

// File: rtl/dfa_adder.sv
module dfa_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         int_mode,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum[i]     = mm_pkg::cell_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = mm_pkg::cell_carry(x[i], y[i], chain[i], int_mode);
  end

  assign cout = chain[W];
endmodule

// File: rtl/mm_iter.sv
module mm_iter #(
  parameter int K = 8,
  localparam int W = K + 2
) (
  input  logic [W-1:0] acc,
  input  logic [K-1:0] mcand,
  input  logic [W-1:0] mod_ext,
  input  logic         a_bit,
  input  logic         int_mode,
  output logic [W-1:0] next_acc,
  output logic         ovf
);
  logic [W-1:0] add1, add2, s1, s2;
  logic         co1, co2, q_bit;

  assign add1 = a_bit ? {2'b00, mcand} : '0;

  dfa_adder #(.W(W)) u_add_b (
    .x(acc), .y(add1), .cin(1'b0), .int_mode(int_mode), .sum(s1), .cout(co1)
  );

  assign q_bit = s1[0];
  assign add2  = q_bit ? mod_ext : '0;

  dfa_adder #(.W(W)) u_add_m (
    .x(s1), .y(add2), .cin(1'b0), .int_mode(int_mode), .sum(s2), .cout(co2)
  );

  // Halving is a plain shift in both fields.
  assign next_acc = {1'b0, s2[W-1:1]};
  assign ovf      = co1 | co2 | s2[0];
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
  parameter int K = 8,
  localparam int CW = $clog2(K + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic iter_step,
  output logic fix_step,
  output logic busy,
  output logic done
);
  import mm_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(K - 1);

  mm_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load      = start && (state_q == ST_IDLE);
  assign iter_step = (state_q == ST_RUN);
  assign fix_step  = (state_q == ST_FIX);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fix_step;
      unique case (state_q)
        ST_IDLE: if (load) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_FIX;
          cnt_q <= cnt_q + 1'b1;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dualfield_mont_mul.sv
module dualfield_mont_mul #(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         field_sel,
  input  logic [K-1:0] op_a,
  input  logic [K-1:0] op_b,
  input  logic [K-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [K-1:0] product
);
  localparam int W = K + 2;

  logic         load, iter_step, fix_step;
  logic [K-1:0] a_sh, b_q, m_q, prod_q;
  logic         fsel_q;
  logic [W-1:0] acc_q, acc_next, mod_ext, diff;
  logic         no_borrow, sub_taken, ovf;

  mm_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .iter_step(iter_step), .fix_step(fix_step), .busy(busy), .done(done)
  );

  // Polynomial mode carries the implied x^K term of the field polynomial.
  assign mod_ext = fsel_q ? {2'b00, m_q} : {2'b01, m_q};

  mm_iter #(.K(K)) u_iter (
    .acc(acc_q), .mcand(b_q), .mod_ext(mod_ext), .a_bit(a_sh[0]),
    .int_mode(fsel_q), .next_acc(acc_next), .ovf(ovf)
  );

  // Final correction: acc - p via the same carry-gated cells, carries enabled.
  dfa_adder #(.W(W)) u_sub (
    .x(acc_q), .y(~{2'b00, m_q}), .cin(1'b1), .int_mode(1'b1),
    .sum(diff), .cout(no_borrow)
  );

  assign sub_taken = fsel_q & no_borrow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh   <= '0;
      b_q    <= '0;
      m_q    <= '0;
      fsel_q <= 1'b0;
      acc_q  <= '0;
      prod_q <= '0;
    end else begin
      if (load) begin
        a_sh   <= op_a;
        b_q    <= op_b;
        m_q    <= modulus;
        fsel_q <= field_sel;
        acc_q  <= '0;
      end else if (iter_step) begin
        a_sh  <= a_sh >> 1;
        acc_q <= acc_next;
      end
      if (fix_step) prod_q <= sub_taken ? diff[K-1:0] : acc_q[K-1:0];
    end
  end

  assign product = prod_q;
endmodule

module mm_checker #(
  parameter int K = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         fsel_q,
  input logic [K-1:0] m_q,
  input logic [K-1:0] product,
  input logic         iter_step,
  input logic         fix_step,
  input logic         sub_taken,
  input logic         ovf
);
  logic [31:0] it_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) it_cnt <= '0;
    else if (start && !busy) it_cnt <= '0;
    else if (iter_step) it_cnt <= it_cnt + 1;
  end

  a_r4_iter_count: assert property (@(posedge clk) disable iff (!rst_n)
    fix_step |-> (it_cnt == 32'(K)));
  a_r4_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_step |=> $stable(product));
  a_r7_keep_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fix_step) |=> busy);
  a_r8_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fsel_q) |-> (product < m_q));
  a_r2_no_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_step && !fsel_q) |-> !sub_taken);
  a_r1_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    iter_step |-> !ovf);
endmodule

bind dualfield_mont_mul mm_checker #(.K(K)) u_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fsel_q(fsel_q), .m_q(m_q), .product(product), .iter_step(iter_step),
  .fix_step(fix_step), .sub_taken(sub_taken), .ovf(ovf)
);

// File: tb/test_dualfield_mont_mul.sv
module test_dualfield_mont_mul;
  localparam int K = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         field_sel = 1'b0;
  logic [K-1:0] op_a = '0, op_b = '0, modulus = '0;
  logic         busy, done;
  logic [K-1:0] product;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dualfield_mont_mul #(.K(K)) i_dualfield_mont_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
    .op_a(op_a), .op_b(op_b), .modulus(modulus),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Integer reference: reduce the full product, then halve K times mod p.
  function automatic longint ref_int(longint a, longint b, longint p);
    longint x = (a * b) % p;
    for (int i = 0; i < K; i++) begin
      if (x[0]) x = x + p;
      x = x >> 1;
    end
    return x;
  endfunction

  // Polynomial reference: carry-free product, reduce, then divide by x K times.
  function automatic longint ref_poly(longint a, longint b, longint m);
    longint pf = (longint'(1) << K) | m;
    longint x = 0;
    for (int i = 0; i < K; i++) if (a[i]) x = x ^ (b << i);
    for (int d = 2 * K - 2; d >= K; d--) if (x[d]) x = x ^ (pf << (d - K));
    for (int i = 0; i < K; i++) begin
      if (x[0]) x = x ^ pf;
      x = x >> 1;
    end
    return x;
  endfunction

  task automatic run_op(input logic fs, input longint a, input longint b,
                        input longint m, input bit disturb, input string req);
    longint exp = fs ? ref_int(a, b, m) : ref_poly(a, b, m);
    int     cnt = 0;
    bit     busy_ok = 1'b1;
    @(negedge clk);
    field_sel = fs; op_a = K'(a); op_b = K'(b); modulus = K'(m); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      field_sel = ~fs; op_a = ~K'(a); op_b = K'(b) ^ 12'h5a5; modulus = K'(m) ^ 12'h0f0;
    end
    while (!done && cnt < 100) begin
      if (!busy) busy_ok = 1'b0;
      if (disturb && cnt == 3) start = 1'b1;
      if (disturb && cnt == 4) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check({req, " latency"}, cnt, K + 1);
    check("R4 busy during run", busy_ok, 1);
    check("R4 busy low with done", busy, 0);
    check({req, " product"}, product, exp);
    @(negedge clk);
    check("R5 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 busy reset", busy, 0);
    check("R10 done reset", done, 0);
    check("R10 product reset", product, 0);
    rst_n = 1'b1;

    // Directed integer corners
    run_op(1'b1, 4094, 4094, 4095, 1'b0, "R8 p-1 squared");
    run_op(1'b1, 0, 1234, 4095, 1'b0, "R8 zero operand");
    run_op(1'b1, 2, 2, 3, 1'b0, "R8 p=3");
    run_op(1'b1, 1, 1, 4093, 1'b0, "R1 unit operands");
    run_op(1'b1, 4092, 4091, 4093, 1'b0, "R1 large operands");
    // Directed polynomial corners
    run_op(1'b0, 12'hfff, 12'hfff, 12'h009, 1'b0, "R3 all ones");
    run_op(1'b0, 12'h800, 12'hfff, 12'h001, 1'b0, "R3 top bit");
    run_op(1'b0, 0, 12'habc, 12'h053, 1'b0, "R2 zero operand");

    // R6: result holds after done while idle
    held = product;
    repeat (7) @(negedge clk);
    check("R6 product held", product, held);
    check("R6 done stays low", done, 0);

    // R7 and R9: disturb inputs and pulse start mid-run
    run_op(1'b1, 3001, 2002, 4091, 1'b1, "R7 R9 integer disturbed");
    run_op(1'b0, 12'h9c3, 12'h71e, 12'h02b, 1'b1, "R7 R9 poly disturbed");

    // Random mixed traffic
    for (int n = 0; n < 150; n++) begin
      logic   fs = 1'($urandom);
      longint m, a, b;
      if (fs) begin
        m = longint'($urandom_range(4095, 3)) | 1;
        a = longint'($urandom) % m;
        b = longint'($urandom) % m;
        run_op(1'b1, a, b, m, 1'b0, "R1 random integer");
      end else begin
        m = longint'($urandom_range(4095, 0)) | 1;
        a = longint'($urandom_range(4095, 0));
        b = longint'($urandom_range(4095, 0));
        run_op(1'b0, a, b, m, 1'b0, "R2 random polynomial");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule